// File: doc/BRIEF.md
# SMBus Clock-Low Timeout Guard

This block watches the sampled SCL and SDA levels of an SMBus port. It raises a fault when a device holds the clock low longer than a programmed number of prescaler ticks. A prescaled tick input paces all counting, so the programmed limit is a count of ticks. Software chooses that tick and the 12-bit limit so that the fault fires before the 25 to 35 ms maximum clock stretch. A mode bit turns the same counter into a bus-idle detector that measures how long both lines stay high.

A second check runs next to the first. It keeps a separate 12-bit budget for the total time the clock spends low between a start marker and a stop marker, whether or not the low periods are consecutive. Both checks set sticky flags and raise a one-cycle interrupt pulse. A clock-low timeout also raises a one-cycle request to reset the bus logic, because an over-long stretch means the bus has failed.

While detection is enabled, the limit and the mode are frozen. While the extended check is enabled, its budget is frozen. The frozen values can be read back on output ports.

Top module: `smb_lowclk_guard`

## Requirements
- R1: After reset, `to_flag_o`, `ext_flag_o`, `irq_o` and `bus_rst_o` are 0, and `limit_o`, `mode_o` and `budget_o` read 0.
- R2: With `mode_o` = 0 (clock-low mode) and detection enabled, `to_flag_o` becomes 1 after exactly `limit_o`+1 consecutive ticks that sample SCL low. After only `limit_o` such ticks it stays 0.
- R3: In clock-low mode, a tick that samples SCL high sets the run count back to zero. Cycles with `tick_i` = 0 neither advance the count nor clear it.
- R4: With `mode_o` = 1 (bus-idle mode), the count advances on ticks where SCL and SDA are both high. Any other tick sets it back to zero, and the flag rule of R2 applies.
- R5: A configuration write (`cfg_wr_i`) changes `limit_o` and `mode_o` only while detection is disabled. A write that enables detection and carries a new limit takes effect. Later writes made while detection is enabled leave `limit_o` and `mode_o` unchanged.
- R6: Disabling detection sets both counters back to zero and leaves the flags that are already set unchanged. While detection is disabled, no flag sets.
- R7: In the cycle in which `to_flag_o` rises, `irq_o` and `bus_rst_o` are each 1, and each of them lasts exactly one cycle.
- R8: `clr_i` clears both sticky flags. If a flag-setting event happens in the same cycle, the set takes priority.
- R9: `start_i` zeroes the extended counter and arms it. While it is armed, every tick that samples SCL low adds one to the count. `ext_flag_o` sets when the total goes past `budget_o`, which is when tick number `budget_o`+1 is counted.
- R10: An extended-budget event pulses `irq_o` for one cycle and does not assert `bus_rst_o`.
- R11: `stop_i` disarms the extended check. Low ticks after the stop do not count.
- R12: The extended check counts only while both the detection enable and the extended enable are set. `budget_o` ignores writes while the extended enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | Prescaled counting tick, one cycle wide |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Detection enable value to write |
| cfg_ext_en_i | input | 1 | Extended-check enable value to write |
| cfg_mode_i | input | 1 | Mode value to write: 0 = clock low, 1 = bus idle |
| cfg_limit_i | input | 12 | Timeout limit to write, in ticks |
| cfg_budget_i | input | 12 | Extended budget to write, in ticks |
| start_i | input | 1 | Start marker: zeroes and arms the extended counter |
| stop_i | input | 1 | Stop marker: disarms the extended counter |
| clr_i | input | 1 | Clears both sticky flags |
| to_flag_o | output | 1 | Sticky clock-low / idle timeout flag |
| ext_flag_o | output | 1 | Sticky extended-budget flag |
| irq_o | output | 1 | One-cycle interrupt pulse on either event |
| bus_rst_o | output | 1 | One-cycle bus-logic reset request on a timeout |
| limit_o | output | 12 | Limit currently in effect |
| mode_o | output | 1 | Mode currently in effect |
| budget_o | output | 12 | Budget currently in effect |

## Verification
The timeout path is swept over every limit from 0 to 9 in clock-low mode and 0 to 5 in bus-idle mode, using three input patterns:
- A run of exactly the limit number of qualifying ticks, followed by one more tick. This separates "not yet past the limit" from "just past it" and catches any off-by-one in the comparison.
- Two runs that are each one tick short, split by a breaking tick. This shows that the run count restarts and does not accumulate.
- Idle cycles without a tick placed inside runs. This shows that only ticks are counted.

The extended budget is driven with broken-up low periods. The total therefore passes the budget while no single run would pass the limit, which separates the cumulative count from the consecutive one. Further sequences insert stop markers, locked writes and a disabled enable, and each one is followed by a read-back of the outputs.

// File: rtl/smbto_pkg.sv
package smbto_pkg;

  typedef enum logic {
    MODE_SCL_LOW  = 1'b0,
    MODE_BUS_IDLE = 1'b1
  } det_mode_e;

endpackage

// File: rtl/smbto_cfg.sv
module smbto_cfg
  import smbto_pkg::*;
#(
  parameter int LIMIT_W  = 12,
  parameter int BUDGET_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic                en_i,
  input  logic                ext_en_i,
  input  logic                mode_i,
  input  logic [LIMIT_W-1:0]  limit_i,
  input  logic [BUDGET_W-1:0] budget_i,
  output logic                en_o,
  output logic                ext_en_o,
  output det_mode_e           mode_o,
  output logic [LIMIT_W-1:0]  limit_o,
  output logic [BUDGET_W-1:0] budget_o
);

  logic                en_q, en_d;
  logic                ext_en_q, ext_en_d;
  det_mode_e           mode_q, mode_d;
  logic [LIMIT_W-1:0]  limit_q, limit_d;
  logic [BUDGET_W-1:0] budget_q, budget_d;
  logic                det_ce, ext_ce;

  // Limit and mode may change only while detection is off; the budget may
  // change only while the extended check is off.
  assign det_ce = wr_i && !en_q;
  assign ext_ce = wr_i && !ext_en_q;

  always_comb begin
    en_d     = en_q;
    ext_en_d = ext_en_q;
    mode_d   = mode_q;
    limit_d  = limit_q;
    budget_d = budget_q;
    if (wr_i) begin
      en_d     = en_i;
      ext_en_d = ext_en_i;
    end
    if (det_ce) begin
      mode_d  = det_mode_e'(mode_i);
      limit_d = limit_i;
    end
    if (ext_ce) begin
      budget_d = budget_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      ext_en_q <= 1'b0;
    end else if (wr_i) begin
      en_q     <= en_d;
      ext_en_q <= ext_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_SCL_LOW;
      limit_q <= '0;
    end else if (det_ce) begin
      mode_q  <= mode_d;
      limit_q <= limit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      budget_q <= '0;
    end else if (ext_ce) begin
      budget_q <= budget_d;
    end
  end

  assign en_o     = en_q;
  assign ext_en_o = ext_en_q;
  assign mode_o   = mode_q;
  assign limit_o  = limit_q;
  assign budget_o = budget_q;

  // R5
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> ($stable(limit_q) && $stable(mode_q)));

  // R12
  budget_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_en_q |=> $stable(budget_q));

endmodule

// File: rtl/smbto_runcnt.sv
module smbto_runcnt
  import smbto_pkg::*;
#(
  parameter int LIMIT_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic               tick_i,
  input  det_mode_e          mode_i,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic               evt_o
);

  localparam int CW = LIMIT_W + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] limit_ext;
  logic          qualify;
  logic          cnt_ce;
  logic          evt;

  assign limit_ext = {1'b0, limit_i};
  assign qualify   = (mode_i == MODE_SCL_LOW) ? !scl_i : (scl_i && sda_i);
  assign cnt_ce    = !run_i || tick_i;

  always_comb begin
    cnt_d = cnt_q;
    evt   = 1'b0;
    if (!run_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (!qualify) begin
        cnt_d = '0;
      end else if (cnt_q <= limit_ext) begin
        cnt_d = cnt_q + 1'b1;
        evt   = (cnt_q == limit_ext);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign evt_o = evt;

  // R6
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));

  // R2
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit_ext + 1'b1);

endmodule

// File: rtl/smbto_budget.sv
module smbto_budget #(
  parameter int BUDGET_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_i,
  input  logic                tick_i,
  input  logic                scl_i,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic [BUDGET_W-1:0] budget_i,
  output logic                evt_o
);

  localparam int CW = BUDGET_W + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] budget_ext;
  logic          armed_q, armed_d;
  logic          st_ce;
  logic          evt;

  assign budget_ext = {1'b0, budget_i};
  assign st_ce      = !run_i || tick_i || start_i || stop_i;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    evt     = 1'b0;
    if (!run_i) begin
      cnt_d   = '0;
      armed_d = 1'b0;
    end else begin
      if (armed_q && tick_i && !scl_i && (cnt_q <= budget_ext)) begin
        cnt_d = cnt_q + 1'b1;
        evt   = (cnt_q == budget_ext);
      end
      if (stop_i) begin
        armed_d = 1'b0;
      end
      if (start_i) begin
        cnt_d   = '0;
        armed_d = 1'b1;
        evt     = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (st_ce) begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign evt_o = evt;

  // R9
  budget_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= budget_ext + 1'b1);

  // R11
  disarmed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !start_i) |=> $stable(cnt_q) || (cnt_q == '0));

endmodule

// File: rtl/smbto_flags.sv
module smbto_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic to_evt_i,
  input  logic ext_evt_i,
  input  logic clr_i,
  output logic to_flag_o,
  output logic ext_flag_o,
  output logic irq_o,
  output logic bus_rst_o
);

  logic to_flag_q, to_flag_d;
  logic ext_flag_q, ext_flag_d;
  logic irq_q, irq_d;
  logic brst_q, brst_d;

  always_comb begin
    to_flag_d  = to_flag_q;
    ext_flag_d = ext_flag_q;
    if (clr_i) begin
      to_flag_d  = 1'b0;
      ext_flag_d = 1'b0;
    end
    if (to_evt_i)  to_flag_d  = 1'b1;
    if (ext_evt_i) ext_flag_d = 1'b1;
    irq_d  = to_evt_i || ext_evt_i;
    brst_d = to_evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_flag_q  <= 1'b0;
      ext_flag_q <= 1'b0;
      irq_q      <= 1'b0;
      brst_q     <= 1'b0;
    end else begin
      to_flag_q  <= to_flag_d;
      ext_flag_q <= ext_flag_d;
      irq_q      <= irq_d;
      brst_q     <= brst_d;
    end
  end

  assign to_flag_o  = to_flag_q;
  assign ext_flag_o = ext_flag_q;
  assign irq_o      = irq_q;
  assign bus_rst_o  = brst_q;

  // R7
  to_rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_flag_q) |-> (irq_q && brst_q));

  // R7
  brst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brst_q |=> !brst_q);

  // R10
  ext_rise_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_flag_q) |-> irq_q);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !to_evt_i) |=> !to_flag_q);

endmodule

// File: rtl/smb_lowclk_guard.sv
module smb_lowclk_guard
  import smbto_pkg::*;
#(
  parameter int LIMIT_W  = 12,
  parameter int BUDGET_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic                cfg_wr_i,
  input  logic                cfg_en_i,
  input  logic                cfg_ext_en_i,
  input  logic                cfg_mode_i,
  input  logic [LIMIT_W-1:0]  cfg_limit_i,
  input  logic [BUDGET_W-1:0] cfg_budget_i,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                clr_i,
  output logic                to_flag_o,
  output logic                ext_flag_o,
  output logic                irq_o,
  output logic                bus_rst_o,
  output logic [LIMIT_W-1:0]  limit_o,
  output logic                mode_o,
  output logic [BUDGET_W-1:0] budget_o
);

  logic                rst_sync_q1, rst_sync_q2;
  logic                rst_int_n;
  logic                en, ext_en;
  det_mode_e           mode;
  logic [LIMIT_W-1:0]  limit;
  logic [BUDGET_W-1:0] budget;
  logic                to_evt, ext_evt;
  logic                ext_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q1 <= 1'b0;
      rst_sync_q2 <= 1'b0;
    end else begin
      rst_sync_q1 <= 1'b1;
      rst_sync_q2 <= rst_sync_q1;
    end
  end
  assign rst_int_n = rst_sync_q2;

  smbto_cfg #(.LIMIT_W(LIMIT_W), .BUDGET_W(BUDGET_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_i     (cfg_wr_i),
    .en_i     (cfg_en_i),
    .ext_en_i (cfg_ext_en_i),
    .mode_i   (cfg_mode_i),
    .limit_i  (cfg_limit_i),
    .budget_i (cfg_budget_i),
    .en_o     (en),
    .ext_en_o (ext_en),
    .mode_o   (mode),
    .limit_o  (limit),
    .budget_o (budget)
  );

  smbto_runcnt #(.LIMIT_W(LIMIT_W)) u_run (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run_i   (en),
    .tick_i  (tick_i),
    .mode_i  (mode),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .limit_i (limit),
    .evt_o   (to_evt)
  );

  assign ext_run = en && ext_en;

  smbto_budget #(.BUDGET_W(BUDGET_W)) u_budget (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run_i    (ext_run),
    .tick_i   (tick_i),
    .scl_i    (scl_i),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .budget_i (budget),
    .evt_o    (ext_evt)
  );

  smbto_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .to_evt_i   (to_evt),
    .ext_evt_i  (ext_evt),
    .clr_i      (clr_i),
    .to_flag_o  (to_flag_o),
    .ext_flag_o (ext_flag_o),
    .irq_o      (irq_o),
    .bus_rst_o  (bus_rst_o)
  );

  assign limit_o  = limit;
  assign mode_o   = mode;
  assign budget_o = budget;

  // R6
  no_flag_disabled_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!en && !clr_i) |=> !$rose(to_flag_o) && !$rose(ext_flag_o));

endmodule

// File: tb/test_smb_lowclk_guard.sv
module test_smb_lowclk_guard;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, scl, sda;
  logic        cfg_wr, cfg_en, cfg_ext_en, cfg_mode;
  logic [11:0] cfg_limit, cfg_budget;
  logic        start, stop, clr;
  logic        to_flag, ext_flag, irq, bus_rst, mode_rb;
  logic [11:0] limit_rb, budget_rb;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  smb_lowclk_guard i_smb_lowclk_guard (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .scl_i(scl), .sda_i(sda),
    .cfg_wr_i(cfg_wr), .cfg_en_i(cfg_en), .cfg_ext_en_i(cfg_ext_en),
    .cfg_mode_i(cfg_mode), .cfg_limit_i(cfg_limit), .cfg_budget_i(cfg_budget),
    .start_i(start), .stop_i(stop), .clr_i(clr),
    .to_flag_o(to_flag), .ext_flag_o(ext_flag), .irq_o(irq),
    .bus_rst_o(bus_rst), .limit_o(limit_rb), .mode_o(mode_rb),
    .budget_o(budget_rb)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic idle();
    @(negedge clk);
  endtask

  task automatic step(input logic s, input logic d);
    scl = s; sda = d; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0; scl = 1'b1; sda = 1'b1;
  endtask

  task automatic write_cfg(input logic en, input logic ext, input logic md,
                           input int lim, input int bud);
    cfg_wr = 1'b1; cfg_en = en; cfg_ext_en = ext; cfg_mode = md;
    cfg_limit = 12'(lim); cfg_budget = 12'(bud);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_clr();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  task automatic mark(input logic is_start);
    if (is_start) start = 1'b1; else stop = 1'b1;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 0; scl = 1; sda = 1;
    cfg_wr = 0; cfg_en = 0; cfg_ext_en = 0; cfg_mode = 0;
    cfg_limit = 0; cfg_budget = 0; start = 0; stop = 0; clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 to_flag", int'(to_flag), 0);
    check("R1 ext_flag", int'(ext_flag), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 bus_rst", int'(bus_rst), 0);
    check("R1 limit", int'(limit_rb), 0);
    check("R1 budget", int'(budget_rb), 0);

    // Sweep: mode 0 (R2, R3), mode 1 (R4). Qualifying level q_s/q_d,
    // breaking level b_s/b_d.
    for (int md = 0; md < 2; md++) begin
      for (int lim = 0; lim < (md == 0 ? 10 : 6); lim++) begin
        logic q_s, q_d, b_s, b_d;
        q_s = (md == 0) ? 1'b0 : 1'b1; q_d = 1'b1;
        b_s = 1'b1; b_d = (md == 0) ? 1'b1 : 1'b0;
        write_cfg(0, 0, logic'(md), 0, 0);
        write_cfg(1, 0, logic'(md), lim, 0);
        check("R5 limit accepted", int'(limit_rb), lim);
        check("R5 mode accepted", int'(mode_rb), md);
        pulse_clr();
        step(b_s, b_d);
        // Two short runs split by a breaking tick: R3/R4 restart
        for (int k = 0; k < lim; k++) begin step(q_s, q_d); idle(); end
        step(b_s, b_d);
        for (int k = 0; k < lim; k++) step(q_s, q_d);
        check(md == 0 ? "R3 break restarts run" : "R4 break restarts run",
              int'(to_flag), 0);
        step(b_s, b_d);
        // Exactly lim ticks, then one more: R2/R4 boundary
        for (int k = 0; k < lim; k++) begin step(q_s, q_d); idle(); end
        check(md == 0 ? "R2 at limit" : "R4 at limit", int'(to_flag), 0);
        step(q_s, q_d);
        check(md == 0 ? "R2 past limit" : "R4 past limit", int'(to_flag), 1);
        check("R7 irq pulse", int'(irq), 1);
        check("R7 bus_rst pulse", int'(bus_rst), 1);
        idle();
        check("R7 irq one cycle", int'(irq), 0);
        check("R7 bus_rst one cycle", int'(bus_rst), 0);
        step(q_s, q_d);
        check("R2 flag sticky", int'(to_flag), 1);
        pulse_clr();
        check("R8 flag cleared", int'(to_flag), 0);
      end
    end

    // R5 lock: enabled in mode 1 with limit 5; try to rewrite
    write_cfg(1, 0, 1'b0, 77, 0);
    check("R5 limit locked", int'(limit_rb), 5);
    check("R5 mode locked", int'(mode_rb), 1);

    // R6: flag survives disable, counter cleared by disable
    write_cfg(0, 0, 1'b0, 3, 0);
    write_cfg(1, 0, 1'b0, 3, 0);
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1);
    check("R6 flag set", int'(to_flag), 1);
    write_cfg(0, 0, 1'b0, 3, 0);
    check("R6 flag kept on disable", int'(to_flag), 1);
    pulse_clr();
    for (int k = 0; k < 10; k++) step(1'b0, 1'b1);
    check("R6 no flag while disabled", int'(to_flag), 0);
    write_cfg(1, 0, 1'b0, 3, 0);
    step(1'b1, 1'b1);
    for (int k = 0; k < 3; k++) step(1'b0, 1'b1);
    write_cfg(0, 0, 1'b0, 3, 0);
    write_cfg(1, 0, 1'b0, 3, 0);
    for (int k = 0; k < 3; k++) step(1'b0, 1'b1);
    check("R6 counter reset by disable", int'(to_flag), 0);

    // Extended budget 5, limit large: R9, R10
    write_cfg(0, 0, 1'b0, 0, 0);
    write_cfg(1, 1, 1'b0, 200, 5);
    check("R12 budget accepted", int'(budget_rb), 5);
    pulse_clr();
    mark(1'b1);
    step(1'b0, 1'b1); step(1'b0, 1'b1); step(1'b1, 1'b1);
    step(1'b0, 1'b1); idle(); step(1'b0, 1'b1); step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    check("R9 at budget", int'(ext_flag), 0);
    step(1'b0, 1'b1);
    check("R9 past budget", int'(ext_flag), 1);
    check("R10 irq on ext", int'(irq), 1);
    check("R10 no bus_rst on ext", int'(bus_rst), 0);
    check("R9 main flag untouched", int'(to_flag), 0);
    idle();
    check("R10 irq one cycle", int'(irq), 0);
    pulse_clr();
    check("R8 ext flag cleared", int'(ext_flag), 0);

    // R11 stop disarms
    mark(1'b1);
    for (int k = 0; k < 3; k++) step(1'b0, 1'b1);
    mark(1'b0);
    step(1'b1, 1'b1);
    for (int k = 0; k < 10; k++) begin step(1'b0, 1'b1); step(1'b1, 1'b1); end
    check("R11 no count after stop", int'(ext_flag), 0);

    // R12 budget lock and enable dependency
    write_cfg(1, 1, 1'b0, 0, 9);
    check("R12 budget locked", int'(budget_rb), 5);
    write_cfg(0, 1, 1'b0, 0, 9);
    mark(1'b1);
    for (int k = 0; k < 8; k++) begin step(1'b0, 1'b1); step(1'b1, 1'b1); end
    check("R12 no ext count without enable", int'(ext_flag), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule